// File: doc/BRIEF.md
# Double-Buffered Octal Code Register Bank

This block keeps the digital codes for eight converter channels. Each channel has two 12-bit stages. The first is a staging register that software writes. The second is a live register whose value drives the converter. The block takes one decoded 16-bit command word per cycle, qualified by a valid strobe. The top four bits select an operation and the low twelve bits carry a code or a channel mask.

The operations are:
- a staging-only write to one channel;
- a staging-only write to all eight channels;
- a combined staging-and-live write to the lower half of the channels, the upper half, or all of them;
- a masked copy from staging to live;
- a full reset command;
- a no-operation;
- a power-control word, which is passed on to the power controller.

A level-sensitive load input, active low, makes every live register track its staging register while the input is held low. An asynchronous clear input, active low, zeroes every register at once.

Commands take effect on the clock edge that samples them. The live codes and the forwarded power word are visible after that edge.

Top module: `regbank_octal`

## Requirements
- R1: After the synchronous reset `rst` (and therefore at power-up), every staging register and every live code is zero, `shdn_all` is 0 and `pwr_valid` is 0.
- R2: A valid word with opcode 4'h0 changes no register. All live codes stay as they were.
- R3: Opcode 4'h1 zeroes every staging and live register. On the following cycle, `shdn_all` is high for exactly one cycle.
- R4: Opcodes 4'h2 to 4'h9 write the 12 data bits into the staging register of channel 1 to 8 respectively (4'h2 selects channel 1). Live codes do not change.
- R5: Opcode 4'hA writes the data into both registers of channels 1-4. Opcode 4'hB does the same for channels 5-8, and opcode 4'hC for all eight channels. The live codes of the channels not written stay unchanged.
- R6: Opcode 4'hD writes the data into all eight staging registers and leaves the live codes unchanged.
- R7: Opcode 4'hE copies staging to live for each channel whose mask bit is 1. Channel k (1..8) uses data bit k+3, so channel 8 uses bit 11 and channel 1 uses bit 4. Channels with a 0 mask bit keep their live code.
- R8: While `load_n` is sampled low, each live register takes its staging register's new value on the same edge. A staging-only write therefore appears at the output one cycle after it is presented.
- R9: A write-through command presented while `load_n` is low leaves the newly written data in the live register.
- R10: Driving `clr_n` low zeroes all registers at once, without waiting for a clock edge, and drives `shdn_all` high for as long as `clr_n` is held low.
- R11: Opcode 4'hF changes no code register. One cycle after the word, `pwr_valid` is high for one cycle, with `pwr_bits` equal to the word's 12 data bits.
- R12: A word presented while `word_valid` is low has no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear of all registers, active low |
| load_n | input | 1 | Level load, active low: live registers track staging registers |
| word_valid | input | 1 | Qualifies `word_in` for one cycle |
| word_in | input | 16 | Command word: bits 15:12 opcode, bits 11:0 data |
| codes_out | output | 96 | Live codes; channel k occupies bits [12k-1 : 12k-12] |
| shdn_all | output | 1 | Request to the power controller to shut down all channels |
| pwr_valid | output | 1 | A power-control word is being forwarded |
| pwr_bits | output | 12 | Data field of the forwarded power-control word |

## Verification
Two mechanisms can try to update the same live register on the same edge. One is the level load held low; the other is a command that also targets the live register, either a write-through or a masked copy. The bench holds `load_n` low and issues staging-only, write-through and masked-copy words on consecutive cycles. It judges each edge against a model in which the register's new staging value wins. A second collision is the asynchronous clear falling between edges after a burst of writes. The outputs are sampled a fraction of a cycle later, before any clock edge, and must already be zero.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int OP_W   = 4;
    localparam int CODE_W = 12;
    localparam int WORD_W = OP_W + CODE_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'h0,
        OP_RESET   = 4'h1,
        OP_STG_C1  = 4'h2,
        OP_STG_C8  = 4'h9,
        OP_WT_LOW  = 4'hA,
        OP_WT_HIGH = 4'hB,
        OP_WT_ALL  = 4'hC,
        OP_STG_ALL = 4'hD,
        OP_XFER    = 4'hE,
        OP_POWER   = 4'hF
    } opcode_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [CODE_W-1:0] data;
    } word_t;

    function automatic logic is_single_stage(input logic [OP_W-1:0] op);
        return (op >= OP_STG_C1) && (op <= OP_STG_C8);
    endfunction

endpackage

// File: rtl/rb_cmd_decode.sv
module rb_cmd_decode
    import regbank_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 12
) (
    input  logic           valid,
    input  word_t          w,
    output logic [NCH-1:0] in_we,
    output logic [NCH-1:0] out_we,
    output logic [NCH-1:0] xfer,
    output logic           clr_all,
    output logic           pwr_fwd
);
    localparam int HALF     = NCH / 2;
    localparam int MASK_LSB = DW - NCH;

    always_comb begin
        in_we   = '0;
        out_we  = '0;
        xfer    = '0;
        clr_all = 1'b0;
        pwr_fwd = 1'b0;
        if (valid) begin
            for (int i = 0; i < NCH; i++) begin
                if (is_single_stage(w.op) && (int'(w.op) - int'(OP_STG_C1) == i))
                    in_we[i] = 1'b1;
                if (w.op == OP_STG_ALL)
                    in_we[i] = 1'b1;
                if ((w.op == OP_WT_ALL) ||
                    ((w.op == OP_WT_LOW)  && (i <  HALF)) ||
                    ((w.op == OP_WT_HIGH) && (i >= HALF))) begin
                    in_we[i]  = 1'b1;
                    out_we[i] = 1'b1;
                end
                if (w.op == OP_XFER)
                    xfer[i] = w.data[MASK_LSB + i];
            end
            clr_all = (w.op == OP_RESET);
            pwr_fwd = (w.op == OP_POWER);
        end
    end

    // R4: a single-channel staging opcode selects exactly one channel
    always_comb begin
        if (valid && is_single_stage(w.op))
            assert_single_target_R4: assert ($onehot(in_we) && (out_we == '0));
    end

endmodule

// File: rtl/rb_channel.sv
module rb_channel #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_n,
    input  logic          load_n,
    input  logic          in_we,
    input  logic          out_we,
    input  logic          xfer,
    input  logic          clr_cmd,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] out_q
);
    logic [DW-1:0] in_q;
    logic [DW-1:0] in_nxt;

    always_comb in_nxt = in_we ? data : in_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            in_q  <= '0;
            out_q <= '0;
        end else if (rst || clr_cmd) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            in_q <= in_nxt;
            if (!load_n)
                out_q <= in_nxt;
            else if (out_we)
                out_q <= data;
            else if (xfer)
                out_q <= in_q;
        end
    end

    assert_reset_cmd_R3: assert property (@(posedge clk) disable iff (rst || !clr_n)
        clr_cmd |=> (out_q == '0) && (in_q == '0));

    assert_write_through_R5: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (out_we && load_n && !clr_cmd) |=> (out_q == $past(data)));

    assert_level_track_R8: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (!load_n && !clr_cmd) |=> (out_q == in_q));

    assert_collision_new_data_R9: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (out_we && !load_n && !clr_cmd) |=> (out_q == $past(data)));

endmodule

// File: rtl/regbank_octal.sv
module regbank_octal
    import regbank_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              load_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic [NCH*DW-1:0] codes_out,
    output logic              shdn_all,
    output logic              pwr_valid,
    output logic [DW-1:0]     pwr_bits
);
    word_t          w;
    logic [NCH-1:0] in_we, out_we, xfer;
    logic           clr_all, pwr_fwd, shdn_q;

    assign w = word_t'(word_in);

    rb_cmd_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .valid   (word_valid),
        .w       (w),
        .in_we   (in_we),
        .out_we  (out_we),
        .xfer    (xfer),
        .clr_all (clr_all),
        .pwr_fwd (pwr_fwd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        rb_channel #(.DW(DW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .clr_n   (clr_n),
            .load_n  (load_n),
            .in_we   (in_we[g]),
            .out_we  (out_we[g]),
            .xfer    (xfer[g]),
            .clr_cmd (clr_all),
            .data    (w.data[DW-1:0]),
            .out_q   (codes_out[g*DW +: DW])
        );
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            shdn_q    <= 1'b0;
            pwr_valid <= 1'b0;
            pwr_bits  <= '0;
        end else if (rst) begin
            shdn_q    <= 1'b0;
            pwr_valid <= 1'b0;
            pwr_bits  <= '0;
        end else begin
            shdn_q    <= clr_all;
            pwr_valid <= pwr_fwd;
            if (pwr_fwd)
                pwr_bits <= w.data[DW-1:0];
        end
    end

    assign shdn_all = shdn_q | ~clr_n;

    assert_nop_stable_R2: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (word_valid && (w.op == OP_NOP) && load_n) |=> $stable(codes_out));

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> ((codes_out == '0) && shdn_all));

    assert_power_fwd_R11: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (word_valid && (w.op == OP_POWER)) |=>
            (pwr_valid && (pwr_bits == $past(word_in[DW-1:0])) && $stable(codes_out)));

    assert_idle_ignored_R12: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (!word_valid && load_n) |=> ($stable(codes_out) && !pwr_valid && !shdn_all));

endmodule

// File: tb/tb_regbank_octal.sv
`timescale 1ns/1ps
module tb_regbank_octal;
    localparam int NCH = 8;
    localparam int DW  = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr_n = 1'b1;
    logic              load_n = 1'b1;
    logic              word_valid = 1'b0;
    logic [15:0]       word_in = '0;
    logic [NCH*DW-1:0] codes_out;
    logic              shdn_all, pwr_valid;
    logic [DW-1:0]     pwr_bits;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] m_in  [NCH];
    logic [DW-1:0] m_out [NCH];

    always #2.5 clk = ~clk;

    regbank_octal dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
        .word_valid(word_valid), .word_in(word_in),
        .codes_out(codes_out), .shdn_all(shdn_all),
        .pwr_valid(pwr_valid), .pwr_bits(pwr_bits)
    );

    function automatic logic [NCH*DW-1:0] expect_vec();
        logic [NCH*DW-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*DW +: DW] = m_out[i];
        return v;
    endfunction

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_codes(input string tag);
        n_chk++;
        if (codes_out !== expect_vec()) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, codes_out, expect_vec());
        end
    endtask

    // Model computed from the requirement list
    task automatic model_apply(input logic [3:0] op, input logic [11:0] d);
        for (int i = 0; i < NCH; i++) begin
            logic [DW-1:0] nin;
            logic wt;
            nin = m_in[i];
            wt  = (op == 4'hA && i < 4) || (op == 4'hB && i >= 4) || (op == 4'hC);
            if (op >= 4'h2 && op <= 4'h9 && int'(op) - 2 == i) nin = d;
            if (op == 4'hD || wt) nin = d;
            if (op == 4'h1) begin
                m_in[i]  = '0;
                m_out[i] = '0;
            end else begin
                if (!load_n)                      m_out[i] = nin;
                else if (wt)                      m_out[i] = d;
                else if (op == 4'hE && d[4 + i])  m_out[i] = m_in[i];
                m_in[i] = nin;
            end
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [11:0] d, input string tag);
        @(negedge clk);
        word_valid = 1'b1;
        word_in    = {op, d};
        @(negedge clk);
        word_valid = 1'b0;
        word_in    = 16'h0;
        model_apply(op, d);
        check_codes(tag);
        if (op == 4'hF) begin
            check_bit(pwr_valid, 1'b1, "R11 pwr_valid");
            n_chk++;
            if (pwr_bits !== d) begin
                n_bad++;
                $display("FAIL R11 pwr_bits: actual %h expected %h", pwr_bits, d);
            end
        end
        if (op == 4'h1) check_bit(shdn_all, 1'b1, "R3 shdn_all pulse");
    endtask

    task automatic model_zero();
        for (int i = 0; i < NCH; i++) begin
            m_in[i]  = '0;
            m_out[i] = '0;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_zero();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_codes("R1 reset codes");
        check_bit(shdn_all, 1'b0, "R1 shdn_all");
        check_bit(pwr_valid, 1'b0, "R1 pwr_valid");

        // R4: staging-only writes per channel
        for (int i = 0; i < NCH; i++)
            send(4'(i + 2), 12'(12'h111 * (i + 1)), "R4 staging write");
        // R2: no-op with full data
        send(4'h0, 12'hFFF, "R2 nop");

        // R12: word ignored while valid low
        @(negedge clk);
        word_in = {4'hC, 12'hABC};
        repeat (3) @(negedge clk);
        check_codes("R12 invalid word ignored");
        check_bit(pwr_valid, 1'b0, "R12 pwr_valid");
        word_in = 16'h0;

        // R7: transfer of staged values, one mask
        send(4'hE, 12'b0000_0101_0000, "R7 masked copy ch1 ch3");
        // R6/R7: exhaustive mask sweep
        for (int m = 0; m < 256; m++) begin
            send(4'hD, 12'((m * 37 + 5) & 12'hFFF), "R6 staging all");
            send(4'hE, {8'(m), 4'hA}, "R7 masked copy sweep");
        end

        // R5: grouped write-through
        send(4'hA, 12'h123, "R5 write-through low half");
        send(4'hB, 12'h456, "R5 write-through high half");
        send(4'hC, 12'h789, "R5 write-through all");

        // R11: power word leaves codes unchanged
        send(4'h5, 12'h3C3, "R4 staging write ch4");
        send(4'hF, 12'h5A5, "R11 power word");
        @(negedge clk);
        check_bit(pwr_valid, 1'b0, "R11 pwr_valid single cycle");

        // R8: level load tracking
        @(negedge clk);
        load_n = 1'b0;
        @(negedge clk);
        model_apply(4'h0, 12'h0);
        check_codes("R8 load low copies staged values");
        for (int i = 0; i < NCH; i++)
            send(4'(i + 2), 12'(12'hF0F - i * 12'h101), "R8 tracking staging write");
        // R9: collision of write-through and level load
        send(4'hA, 12'hBEE, "R9 write-through with load low");
        send(4'hC, 12'hCAB, "R9 write-through all with load low");
        send(4'hE, 12'hFF0, "R9 masked copy with load low");
        @(negedge clk);
        load_n = 1'b1;

        // R3: reset command
        send(4'hC, 12'h777, "R5 preload");
        send(4'h1, 12'hFFF, "R3 reset command");
        @(negedge clk);
        check_bit(shdn_all, 1'b0, "R3 shdn_all one cycle");
        send(4'hE, 12'hFF0, "R3 staging cleared");

        // R10: asynchronous clear between edges
        send(4'hC, 12'h9D1, "R5 preload");
        send(4'h3, 12'h222, "R4 preload staging");
        @(negedge clk);
        #1;
        clr_n = 1'b0;
        #0.5;
        model_zero();
        check_codes("R10 immediate clear");
        check_bit(shdn_all, 1'b1, "R10 shdn_all during clear");
        @(negedge clk);
        clr_n = 1'b1;
        send(4'hE, 12'hFF0, "R10 staging cleared");

        // R1: synchronous reset mid-run
        send(4'hC, 12'h4E4, "R5 preload");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_zero();
        check_codes("R1 reset mid-run");
        send(4'hE, 12'hFF0, "R1 staging cleared by reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule